// File: doc/BRIEF.md
# Dual-Port Collision Alert Generator

This block sits beside a shared-clock dual-port memory. It watches the registered access of each port: the enable, the read/write flag and the address. It flags the ports whose data may have been spoiled because both ports touched the same word in the same cycle. Each port has one active-low alert output.

An alert is directional. A port that reads while its peer writes is alerted, because it may have captured a word in transition. A port whose peer only reads is left alone. Two readers never raise anything.

An alert lasts exactly one cycle. The block clears it on its own, so the memory's user never has to acknowledge it. The cycle that follows an alert is spent resetting that port's flag. A collision that would land in that cycle is lost for that port only. Under a steady run of collisions, the alert therefore toggles every other cycle.

The user can count alerts during a burst and decide whether to repeat the burst.

Top module: `collide_alert_top`

## Requirements
- R1: When both ports are enabled, use the same address and both read (write flag 0), neither alert goes low for that access.
- R2: When both ports are enabled on the same address and exactly one port writes (write flag 1), only the reading port's alert goes low. The writing port's alert stays high.
- R3: When both ports are enabled on the same address and both write, both alerts go low.
- R4: Alerts are active low. An alert that goes low returns high after exactly one cycle.
- R5: An access presented before rising edge k shows its alert low in the cycle that follows rising edge k+1, and in no other cycle.
- R6: If a port's alert is low in a cycle, a collision that would alert that port in the next cycle is dropped for that port. The alert stays high.
- R7: After a dropped collision, a collision in the following cycle alerts again. A continuous run of colliding accesses makes the alert go low every other cycle, starting with the first access.
- R8: An access in which either port's enable is 0 never raises an alert, whatever the addresses and write flags.
- R9: The dropping of R6 is tracked per port. A collision landing in one port's reset cycle still alerts the other port if that port is not itself in its reset cycle.
- R10: Accesses by both ports to different addresses raise no alert, even when both write.
- R11: While reset (active low) is held, and in the first cycle after it, both alerts are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_en | input | 1 | Port A registered enable, 1 = access |
| a_wr | input | 1 | Port A registered write flag, 1 = write, 0 = read |
| a_addr | input | ADDR_W | Port A registered address |
| b_en | input | 1 | Port B registered enable, 1 = access |
| b_wr | input | 1 | Port B registered write flag, 1 = write, 0 = read |
| b_addr | input | ADDR_W | Port B registered address |
| a_alert_n | output | 1 | Port A collision alert, active low |
| b_alert_n | output | 1 | Port B collision alert, active low |

## Verification
Same-address accesses are driven in all four read/write pairings. This separates the directional rule (R1, R2, R3) from a plain address match. Disabled ports and differing addresses show that the enable and the full address take part in the match.

Pairs of collisions, triples and a long unbroken run expose the self-clearing reset cycle. They distinguish a latched flag from a one-cycle pulse, and a dropped collision from a missing one.

A write/read collision followed at once by a write/write collision shows that each port keeps its own reset cycle.

// File: rtl/collide_alert_pkg.sv
package collide_alert_pkg;

  localparam int NUM_PORTS = 2;

  // A port's data is suspect when the word matched and the other port wrote it.
  function automatic logic peer_spoils(input logic word_match, input logic peer_write);
    return word_match & peer_write;
  endfunction

  // Next alert state: a pending hit raises the alert unless the port is
  // spending this cycle clearing a previous one.
  function automatic logic next_alert(input logic pending_hit, input logic clearing);
    return pending_hit & ~clearing;
  endfunction

endpackage

// File: rtl/collide_addr_match.sv
module collide_addr_match #(
  parameter int ADDR_W = 19
) (
  input  logic              en_a,
  input  logic              en_b,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  output logic              word_match
);

  always_comb begin
    word_match = en_a & en_b & (addr_a == addr_b);
  end

endmodule

// File: rtl/collide_port_flag.sv
module collide_port_flag
  import collide_alert_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic raw_hit,
  output logic hit_q,
  output logic clearing,
  output logic alert_n
);

  logic alert_q;

  // Stage 1 captures the hit at the first edge.
  // Stage 2 drives the alert at the second edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q   <= 1'b0;
      alert_q <= 1'b0;
    end else begin
      hit_q   <= raw_hit;
      alert_q <= next_alert(hit_q, alert_q);
    end
  end

  assign clearing = alert_q;
  assign alert_n  = ~alert_q;

endmodule

// File: rtl/collide_alert_top.sv
module collide_alert_top
  import collide_alert_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              a_wr,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              b_en,
  input  logic              b_wr,
  input  logic [ADDR_W-1:0] b_addr,
  output logic              a_alert_n,
  output logic              b_alert_n
);

  logic                 same_word;
  logic [NUM_PORTS-1:0] peer_wr;
  logic [NUM_PORTS-1:0] port_raw;
  logic [NUM_PORTS-1:0] port_hit_q;
  logic [NUM_PORTS-1:0] port_clearing;
  logic [NUM_PORTS-1:0] port_alert_n;

  collide_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .en_a       (a_en),
    .en_b       (b_en),
    .addr_a     (a_addr),
    .addr_b     (b_addr),
    .word_match (same_word)
  );

  // Index 0 is port A. Its peer is B, so its hazard comes from b_wr.
  assign peer_wr = {a_wr, b_wr};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign port_raw[p] = peer_spoils(same_word, peer_wr[p]);

    collide_port_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_hit  (port_raw[p]),
      .hit_q    (port_hit_q[p]),
      .clearing (port_clearing[p]),
      .alert_n  (port_alert_n[p])
    );
  end

  assign a_alert_n = port_alert_n[0];
  assign b_alert_n = port_alert_n[1];

endmodule

// File: rtl/collide_alert_checker.sv
module collide_alert_checker #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              a_en,
  input logic              a_wr,
  input logic [ADDR_W-1:0] a_addr,
  input logic              b_en,
  input logic              b_wr,
  input logic [ADDR_W-1:0] b_addr,
  input logic              a_alert_n,
  input logic              b_alert_n,
  input logic [1:0]        hit_q
);

  logic same;
  assign same = a_en && b_en && (a_addr == b_addr);

  AST_PAIR_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (same && !a_wr && !b_wr) |=> ##1 (a_alert_n && b_alert_n)); // R1

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_en && b_en) |=> ##1 (a_alert_n && b_alert_n)); // R8

  AST_A_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !a_alert_n |=> a_alert_n); // R4

  AST_B_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !b_alert_n |=> b_alert_n); // R4

  AST_A_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (same && b_wr) ##1 a_alert_n |=> !a_alert_n); // R5

  AST_B_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (same && a_wr) ##1 b_alert_n |=> !b_alert_n); // R5

  AST_A_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(a_alert_n) |-> $past(hit_q[0])); // R5

  AST_B_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(b_alert_n) |-> $past(hit_q[1])); // R5

  AST_A_DROP_IN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_alert_n && hit_q[0]) |=> a_alert_n); // R6

endmodule

bind collide_alert_top collide_alert_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .a_en      (a_en),
  .a_wr      (a_wr),
  .a_addr    (a_addr),
  .b_en      (b_en),
  .b_wr      (b_wr),
  .b_addr    (b_addr),
  .a_alert_n (a_alert_n),
  .b_alert_n (b_alert_n),
  .hit_q     (port_hit_q)
);

// File: tb/sim_collide_alert_top.sv
module sim_collide_alert_top;

  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          a_en = 1'b0, a_wr = 1'b0, b_en = 1'b0, b_wr = 1'b0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic          a_alert_n, b_alert_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int    due;
    bit    exp_a;
    bit    exp_b;
    string tag;
  } item_t;

  item_t sb[$];
  bit    last_a = 0, last_b = 0;

  always #10 clk = ~clk; // 50 MHz

  collide_alert_top #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_wr(a_wr), .a_addr(a_addr),
    .b_en(b_en), .b_wr(b_wr), .b_addr(b_addr),
    .a_alert_n(a_alert_n), .b_alert_n(b_alert_n)
  );

  // Driver: applies one access at a falling edge and predicts its alerts.
  task automatic drive(input bit ea, input bit wa, input logic [AW-1:0] aa,
                       input bit eb, input bit wb, input logic [AW-1:0] ab,
                       input string tag);
    item_t it;
    bit    collide;
    @(negedge clk);
    a_en = ea; a_wr = wa; a_addr = aa;
    b_en = eb; b_wr = wb; b_addr = ab;
    collide  = ea && eb && (aa == ab);
    it.exp_a = collide && wb && !last_a;   // A suffers from B's write
    it.exp_b = collide && wa && !last_b;   // B suffers from A's write
    last_a   = it.exp_a;
    last_b   = it.exp_b;
    it.due   = cyc + 2;
    it.tag   = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, '0, 0, 0, '0, "R4 R5 quiet");
  endtask

  // Monitor: counts rising edges and compares in the middle of the high phase.
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #5;
      while (sb.size() > 0 && sb[0].due == cyc) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if ((a_alert_n !== !it.exp_a) || (b_alert_n !== !it.exp_b)) begin
          errors++;
          $display("FAIL %s: alert_n a=%b b=%b expected a=%b b=%b",
                   it.tag, a_alert_n, b_alert_n, !it.exp_a, !it.exp_b);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (a_alert_n !== 1'b1 || b_alert_n !== 1'b1) begin
      errors++;
      $display("FAIL R11: in reset a=%b b=%b expected 1 1", a_alert_n, b_alert_n);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (a_alert_n !== 1'b1 || b_alert_n !== 1'b1) begin
      errors++;
      $display("FAIL R11: after reset a=%b b=%b expected 1 1", a_alert_n, b_alert_n);
    end

    drive(1, 0, 19'h7FFFF, 1, 0, 19'h7FFFF, "R1 read/read");
    idle(3);
    drive(1, 1, 19'h00123, 1, 0, 19'h00123, "R2 A writes");
    idle(3);
    drive(1, 0, 19'h40000, 1, 1, 19'h40000, "R2 B writes");
    idle(3);
    drive(1, 1, 19'h7FFFE, 1, 1, 19'h7FFFE, "R3 both write");
    idle(3);
    drive(1, 1, 19'h00010, 1, 1, 19'h00011, "R10 differ");
    drive(1, 1, 19'h40010, 1, 1, 19'h00010, "R10 top bit");
    idle(3);
    drive(0, 1, 19'h00055, 1, 1, 19'h00055, "R8 A off");
    drive(1, 1, 19'h00055, 0, 1, 19'h00055, "R8 B off");
    idle(3);
    drive(1, 1, 19'h00200, 1, 1, 19'h00200, "R6 first");
    drive(1, 1, 19'h00200, 1, 1, 19'h00200, "R6 dropped");
    idle(3);
    for (int i = 0; i < 3; i++) drive(1, 1, 19'h00300, 1, 1, 19'h00300, "R7 triple");
    idle(3);
    for (int i = 0; i < 8; i++) drive(1, 1, 19'(i), 1, 1, 19'(i), "R7 run");
    idle(3);
    drive(1, 1, 19'h01000, 1, 0, 19'h01000, "R9 B alerted");
    drive(1, 1, 19'h01000, 1, 1, 19'h01000, "R9 A alerts B drops");
    idle(3);
    drive(1, 0, 19'h02000, 1, 1, 19'h02000, "R9 A alerted");
    drive(1, 1, 19'h02000, 1, 1, 19'h02000, "R9 B alerts A drops");
    idle(4);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule